// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block collects interrupt requests from up to 32 main sources and 11 sub-sources and presents them to a processor as a fast request and a normal request. The sub-sources sit in front of the main stage. They are grouped three at a time, and each group that has an unmasked pending member raises one fixed main source bit. Each request input comes in two flavours. An edge flavour pends its bit once on a rising transition. A level flavour keeps its bit pending for as long as the input stays high.

Software reaches eight 32-bit registers through a word-indexed write port and a combinational read port. Three of the registers are pending registers and are cleared by writing ones. The others are overwritten by a write. On every clock the controller merges requests, applies register writes and re-evaluates the arbitration, all in the same clock. A pending source whose mode bit is set takes the fast path and holds off normal selection. Otherwise the lowest-numbered active source competes for the in-service slot, and the index of the source that wins is reported.

Top module: `irq_two_level`

## Requirements
- R1: After reset, the registers read: source pending 0, mode 0, mask 0xFFFFFFFF, priority 0x7F, in-service 0, offset 0, sub-source pending 0, sub-source mask 0x7FF. `fiq_o` and `irq_o` are low.
- R2: `reg_idx` selects the register: 0 source pending, 1 mode, 2 mask, 3 priority, 4 in-service, 5 offset (5 bits wide), 6 sub-source pending (11 bits), 7 sub-source mask (11 bits). A write to index 1, 2, 3, 5 or 7 replaces the stored value, keeping only the field width. A read has no side effect.
- R3: A write to index 0, 4 or 6 clears each bit written as one and leaves every other bit unchanged.
- R4: A rising edge on an edge request input sets its pending bit. Holding the input high does not set the bit again once software has cleared it.
- R5: While a level request input is high, its pending bit is set on every clock, so a clearing write does not stick.
- R6: A falling transition on any request input, edge or level, on either stage, clears that pending bit.
- R7: Unmasked sub-sources (pending and not masked) set main pending bits. Any of sub bits 0–2 sets bit 28, any of 3–5 sets bit 23, and any of 6–8 sets bit 15. Masked sub-sources, and sub bits 9–10, set no main bit.
- R8: Active sources are source pending AND NOT mask. If any active source also has its mode bit set, `fiq_o` is high and in-service is left as it is. Otherwise `fiq_o` is low.
- R9: Without a fast request, the lowest-numbered active source loads its one-hot value into in-service and its index into offset. The load happens only when in-service is zero or holds a larger value. In-service is never more than one-hot.
- R10: `irq_o` is high exactly while in-service is nonzero, and `irq_index` shows the offset register.
- R11: An input change or register write sampled at a clock edge is reflected in the registers and outputs right after that same edge.
- R12: The priority register does not change which source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index (byte-address bits 4:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the indexed register |
| main_edge_req | input | 32 | Edge-sensitive main requests |
| main_level_req | input | 32 | Level-sensitive main requests |
| sub_edge_req | input | 11 | Edge-sensitive sub-source requests |
| sub_level_req | input | 11 | Level-sensitive sub-source requests |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| irq_index | output | 5 | Index of the in-service normal source |

## Verification
A corrupted pending or mask bit shows up within one clock as the wrong `irq_index` or a spurious `fiq_o`. This holds because arbitration reruns on every edge. A wrong in-service value is more dangerous, because it persists. A stale larger value lets a lower-numbered source replace it. A stale smaller value blocks the correct source until software clears it. The bench therefore walks clear-and-reselect sequences and reads in-service back after each write. A broken group funnel or level re-pend shows only through source-pending readback, since the main mask can hide it from the outputs.

// File: rtl/irq_two_level_pkg.sv
// Package: shared register selector and sub-source group layout.
// Assumes the register port is 32 bits and the group map is fixed.
package irq_two_level_pkg;
    localparam int REG_W      = 32;
    localparam int GROUPS     = 3;
    localparam int GROUP_SIZE = 3;
    localparam logic [REG_W-1:0] PRIO_RESET = 32'h0000_007F;

    typedef enum logic [2:0] {
        REG_SRC_PND = 3'd0,
        REG_MODE    = 3'd1,
        REG_MASK    = 3'd2,
        REG_PRIO    = 3'd3,
        REG_INSVC   = 3'd4,
        REG_OFFSET  = 3'd5,
        REG_SUB_PND = 3'd6,
        REG_SUB_MSK = 3'd7
    } reg_sel_e;

    // Main-source bit raised by a given sub-source group.
    function automatic int group_target(input int g);
        case (g)
            0:       return 28;
            1:       return 23;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/irq_req_tracker.sv
// Request tracker: keeps a registered copy of the edge and level request
// vectors and derives per-bit set, clear and hold masks from it.
// Assumes the inputs are already synchronous to clk.
module irq_req_tracker #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] edge_req,
    input  logic [W-1:0] level_req,
    output logic [W-1:0] set_mask,
    output logic [W-1:0] clr_mask,
    output logic [W-1:0] hold_mask
);
    logic [W-1:0] edge_prev_q;
    logic [W-1:0] level_prev_q;

    // Remember last cycle's request levels for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_prev_q  <= '0;
            level_prev_q <= '0;
        end else begin
            edge_prev_q  <= edge_req;
            level_prev_q <= level_req;
        end
    end

    // Rising edge pends, any falling input clears, a high level holds.
    always_comb begin
        set_mask  = edge_req & ~edge_prev_q;
        clr_mask  = (~edge_req & edge_prev_q) | (~level_req & level_prev_q);
        hold_mask = level_req;
    end
endmodule

// File: rtl/irq_sub_funnel.sv
// Sub-source funnel: ORs each group of unmasked sub-source pending bits
// onto its fixed main-source bit. Assumes NUM_SUB covers all groups.
module irq_sub_funnel
    import irq_two_level_pkg::*;
#(
    parameter int NUM_SUB = 11,
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SUB-1:0] sub_pnd,
    input  logic [NUM_SUB-1:0] sub_msk,
    output logic [NUM_SRC-1:0] main_set
);
    localparam int USED = GROUPS * GROUP_SIZE;

    logic [NUM_SUB-1:0] sub_act;
    logic [GROUPS-1:0]  grp_hit;
    logic               unused_tail;

    // Unmasked sub-sources only.
    always_comb sub_act = sub_pnd & ~sub_msk;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_hit[g] = |sub_act[g*GROUP_SIZE +: GROUP_SIZE];
    end

    // Scatter group hits onto their main bits.
    always_comb begin
        main_set = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (grp_hit[g]) main_set[group_target(g)] = 1'b1;
        end
    end

    // Sub bits beyond the grouped range reach no main bit.
    assign unused_tail = ^sub_act[NUM_SUB-1:USED];
endmodule

// File: rtl/irq_arbiter.sv
// Arbiter: decides the fast request and updates the in-service slot and
// offset from the next-state pending, mask and mode values.
// Assumes in-service holds at most one bit (software clears only).
module irq_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] src_pnd,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] mode,
    input  logic [NUM_SRC-1:0] insvc_cur,
    input  logic [IDX_W-1:0]   offset_cur,
    output logic               fiq,
    output logic [NUM_SRC-1:0] insvc_nxt,
    output logic [IDX_W-1:0]   offset_nxt
);
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] onehot;
    logic [IDX_W-1:0]   low_idx;
    logic               found;

    // Active set and fast-path detection.
    always_comb begin
        active = src_pnd & ~mask;
        fiq    = |(active & mode);
    end

    // Lowest-numbered active source by downward scan.
    always_comb begin
        found   = 1'b0;
        low_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                found   = 1'b1;
                low_idx = IDX_W'(i);
            end
        end
        onehot = {{(NUM_SRC-1){1'b0}}, 1'b1} << low_idx;
    end

    // Load the slot only if empty or holding a higher-numbered source.
    always_comb begin
        insvc_nxt  = insvc_cur;
        offset_nxt = offset_cur;
        if (!fiq && found && ((insvc_cur == '0) || (insvc_cur > onehot))) begin
            insvc_nxt  = onehot;
            offset_nxt = low_idx;
        end
    end
endmodule

// File: rtl/irq_two_level.sv
// Top: register file, write decode and next-state assembly of the
// two-level interrupt controller. Every clock applies a write, merges
// request events, funnels sub-sources and re-arbitrates in one step.
// Assumes NUM_SRC <= 32, NUM_SUB >= 9, synchronous request inputs.
module irq_two_level
    import irq_two_level_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_SUB = 11,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         reg_idx,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    input  logic [NUM_SRC-1:0] main_edge_req,
    input  logic [NUM_SRC-1:0] main_level_req,
    input  logic [NUM_SUB-1:0] sub_edge_req,
    input  logic [NUM_SUB-1:0] sub_level_req,
    output logic               fiq_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   irq_index
);
    reg_sel_e reg_sel;
    logic [7:0] wr_hit;

    logic [NUM_SRC-1:0] src_pnd_q, mode_q, mask_q, insvc_q;
    logic [REG_W-1:0]   prio_q;
    logic [IDX_W-1:0]   offset_q;
    logic [NUM_SUB-1:0] sub_pnd_q, sub_msk_q;
    logic               fiq_q;

    logic [NUM_SRC-1:0] m_set, m_clr, m_hold;
    logic [NUM_SUB-1:0] s_set, s_clr, s_hold;

    logic [NUM_SRC-1:0] src_w, src_e, src_n, mode_n, mask_n, insvc_w, insvc_n, funnel_set;
    logic [REG_W-1:0]   prio_n;
    logic [IDX_W-1:0]   offset_w, offset_n;
    logic [NUM_SUB-1:0] sub_w, sub_n, sub_msk_n;
    logic               fiq_n;

    // Decode the write strobe into one-hot register hits.
    always_comb begin
        reg_sel = reg_sel_e'(reg_idx);
        wr_hit  = '0;
        if (wr_en) wr_hit[reg_sel] = 1'b1;
    end

    irq_req_tracker #(.W(NUM_SRC)) u_main_trk (
        .clk(clk), .rst_n(rst_n),
        .edge_req(main_edge_req), .level_req(main_level_req),
        .set_mask(m_set), .clr_mask(m_clr), .hold_mask(m_hold)
    );

    irq_req_tracker #(.W(NUM_SUB)) u_sub_trk (
        .clk(clk), .rst_n(rst_n),
        .edge_req(sub_edge_req), .level_req(sub_level_req),
        .set_mask(s_set), .clr_mask(s_clr), .hold_mask(s_hold)
    );

    // Software writes first: clear-by-one on pending, replace elsewhere.
    always_comb begin
        src_w     = wr_hit[REG_SRC_PND] ? (src_pnd_q & ~wdata[NUM_SRC-1:0]) : src_pnd_q;
        insvc_w   = wr_hit[REG_INSVC]   ? (insvc_q & ~wdata[NUM_SRC-1:0])   : insvc_q;
        sub_w     = wr_hit[REG_SUB_PND] ? (sub_pnd_q & ~wdata[NUM_SUB-1:0]) : sub_pnd_q;
        mode_n    = wr_hit[REG_MODE]    ? wdata[NUM_SRC-1:0] : mode_q;
        mask_n    = wr_hit[REG_MASK]    ? wdata[NUM_SRC-1:0] : mask_q;
        prio_n    = wr_hit[REG_PRIO]    ? wdata              : prio_q;
        offset_w  = wr_hit[REG_OFFSET]  ? wdata[IDX_W-1:0]   : offset_q;
        sub_msk_n = wr_hit[REG_SUB_MSK] ? wdata[NUM_SUB-1:0] : sub_msk_q;
    end

    // Then request events, then held levels re-pend.
    always_comb begin
        src_e = ((src_w | m_set) & ~m_clr) | m_hold;
        sub_n = ((sub_w | s_set) & ~s_clr) | s_hold;
    end

    irq_sub_funnel #(.NUM_SUB(NUM_SUB), .NUM_SRC(NUM_SRC)) u_funnel (
        .sub_pnd(sub_n), .sub_msk(sub_msk_n), .main_set(funnel_set)
    );

    // Grouped sub-sources join the main pending set.
    always_comb src_n = src_e | funnel_set;

    irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .src_pnd(src_n), .mask(mask_n), .mode(mode_n),
        .insvc_cur(insvc_w), .offset_cur(offset_w),
        .fiq(fiq_n), .insvc_nxt(insvc_n), .offset_nxt(offset_n)
    );

    // Commit the evaluated state every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_pnd_q <= '0;
            mode_q    <= '0;
            mask_q    <= '1;
            prio_q    <= PRIO_RESET;
            insvc_q   <= '0;
            offset_q  <= '0;
            sub_pnd_q <= '0;
            sub_msk_q <= '1;
            fiq_q     <= 1'b0;
        end else begin
            src_pnd_q <= src_n;
            mode_q    <= mode_n;
            mask_q    <= mask_n;
            prio_q    <= prio_n;
            insvc_q   <= insvc_n;
            offset_q  <= offset_n;
            sub_pnd_q <= sub_n;
            sub_msk_q <= sub_msk_n;
            fiq_q     <= fiq_n;
        end
    end

    // Side-effect-free read mux, narrow fields zero-extended.
    always_comb begin
        rdata = '0;
        unique case (reg_sel)
            REG_SRC_PND: rdata[NUM_SRC-1:0] = src_pnd_q;
            REG_MODE:    rdata[NUM_SRC-1:0] = mode_q;
            REG_MASK:    rdata[NUM_SRC-1:0] = mask_q;
            REG_PRIO:    rdata              = prio_q;
            REG_INSVC:   rdata[NUM_SRC-1:0] = insvc_q;
            REG_OFFSET:  rdata[IDX_W-1:0]   = offset_q;
            REG_SUB_PND: rdata[NUM_SUB-1:0] = sub_pnd_q;
            REG_SUB_MSK: rdata[NUM_SUB-1:0] = sub_msk_q;
        endcase
    end

    // Processor-facing outputs.
    always_comb begin
        fiq_o     = fiq_q;
        irq_o     = |insvc_q;
        irq_index = offset_q;
    end
endmodule

// File: rtl/irq_two_level_chk.sv
// Checker: temporal properties of the controller, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module irq_two_level_chk
    import irq_two_level_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_SUB = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [2:0]         reg_idx,
    input logic [NUM_SRC-1:0] main_level_req,
    input logic [NUM_SUB-1:0] sub_level_req,
    input logic [NUM_SRC-1:0] src_pnd_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] mode_q,
    input logic [NUM_SRC-1:0] insvc_q,
    input logic [NUM_SUB-1:0] sub_pnd_q,
    input logic [NUM_SUB-1:0] sub_msk_q,
    input logic               fiq_o
);
    // R5: a level held high at an edge is pending right after it.
    assert_level_repend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((src_pnd_q & $past(main_level_req)) == $past(main_level_req)));

    assert_sub_level_repend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sub_pnd_q & $past(sub_level_req)) == $past(sub_level_req)));

    // R9: in-service never holds more than one source.
    assert_insvc_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(insvc_q));

    // R8: fast request only with an active fast-mode source.
    assert_fiq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (|(src_pnd_q & ~mask_q & mode_q)));

    // R8: while fast, in-service only changes by a clearing write.
    assert_fiq_holds_insvc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o && !($past(wr_en) && ($past(reg_idx) == 3'd4))) |-> $stable(insvc_q));

    // R7: each unmasked group keeps its main bit pending.
    for (genvar g = 0; g < GROUPS; g++) begin : g_fun
        assert_group_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (|(sub_pnd_q[g*GROUP_SIZE +: GROUP_SIZE] & ~sub_msk_q[g*GROUP_SIZE +: GROUP_SIZE]))
                |-> src_pnd_q[group_target(g)]);
    end
endmodule

bind irq_two_level irq_two_level_chk #(.NUM_SRC(NUM_SRC), .NUM_SUB(NUM_SUB)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
    .main_level_req(main_level_req), .sub_level_req(sub_level_req),
    .src_pnd_q(src_pnd_q), .mask_q(mask_q), .mode_q(mode_q),
    .insvc_q(insvc_q), .sub_pnd_q(sub_pnd_q), .sub_msk_q(sub_msk_q),
    .fiq_o(fiq_o)
);

// File: tb/irq_two_level_test.sv
`timescale 1ns/1ps
module irq_two_level_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] main_edge_req = '0, main_level_req = '0;
    logic [10:0] sub_edge_req = '0, sub_level_req = '0;
    logic        fiq_o, irq_o;
    logic [4:0]  irq_index;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_two_level uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
        .wdata(wdata), .rdata(rdata),
        .main_edge_req(main_edge_req), .main_level_req(main_level_req),
        .sub_edge_req(sub_edge_req), .sub_level_req(sub_level_req),
        .fiq_o(fiq_o), .irq_o(irq_o), .irq_index(irq_index)
    );

    typedef struct packed {
        logic [31:0] edge_in;
        logic [31:0] level_in;
        logic [31:0] mode;
        logic [31:0] mask;
        logic        fiq;
        logic        irq;
        logic [4:0]  idx;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 32'h0,         32'h0,         32'h0,         1'b0, 1'b1, 5'd8},
        '{32'h0000_0020, 32'h0001_0000, 32'h0,         32'h0,         1'b0, 1'b1, 5'd5},
        '{32'h8000_0001, 32'h0,         32'h0,         32'h0000_0001, 1'b0, 1'b1, 5'd31},
        '{32'h0,         32'h0000_0004, 32'h0000_0004, 32'h0,         1'b1, 1'b0, 5'd0},
        '{32'h0000_0010, 32'h0,         32'h0000_0010, 32'h0000_0010, 1'b0, 1'b0, 5'd0},
        '{32'h0000_0006, 32'h0,         32'h0000_0004, 32'h0,         1'b1, 1'b0, 5'd0},
        '{32'h0000_0006, 32'h0,         32'h0000_0008, 32'h0,         1'b0, 1'b1, 5'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        main_edge_req = '0; main_level_req = '0;
        sub_edge_req = '0; sub_level_req = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = idx; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] idx, input logic [31:0] exp);
        reg_idx = idx;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic drive(input logic [31:0] me, input logic [31:0] ml,
                         input logic [10:0] se, input logic [10:0] sl);
        @(negedge clk);
        main_edge_req = me; main_level_req = ml;
        sub_edge_req = se; sub_level_req = sl;
        @(negedge clk);
    endtask

    task automatic out_check(input string req, input logic f, input logic i, input logic [4:0] x);
        check({req, " fiq"}, 32'(fiq_o), 32'(f));
        check({req, " irq"}, 32'(irq_o), 32'(i));
        if (i) check({req, " index"}, 32'(irq_index), 32'(x));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 reset state
        rd_check("R1 srcpnd", 3'd0, 32'h0);
        rd_check("R1 mode",   3'd1, 32'h0);
        rd_check("R1 mask",   3'd2, 32'hFFFF_FFFF);
        rd_check("R1 prio",   3'd3, 32'h7F);
        rd_check("R1 insvc",  3'd4, 32'h0);
        rd_check("R1 offset", 3'd5, 32'h0);
        rd_check("R1 subpnd", 3'd6, 32'h0);
        rd_check("R1 submsk", 3'd7, 32'h7FF);
        out_check("R1", 1'b0, 1'b0, 5'd0);

        // R2 readback and field widths
        wr(3'd1, 32'hA5A5_0000); rd_check("R2 mode", 3'd1, 32'hA5A5_0000);
        wr(3'd3, 32'h1234_5678); rd_check("R2 prio", 3'd3, 32'h1234_5678);
        rd_check("R2 prio reread", 3'd3, 32'h1234_5678);
        wr(3'd5, 32'hFFFF_FFE2); rd_check("R2 offset", 3'd5, 32'h02);
        wr(3'd7, 32'h0000_0955); rd_check("R2 submsk", 3'd7, 32'h155);
        wr(3'd2, 32'hFFFF_0000); rd_check("R2 mask", 3'd2, 32'hFFFF_0000);

        // Vector table: R8 / R9 / R10 under varied patterns
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wr(3'd2, VECS[v].mask);
            wr(3'd1, VECS[v].mode);
            drive(VECS[v].edge_in, VECS[v].level_in, '0, '0);
            out_check($sformatf("R8/R9/R10 vec%0d", v), VECS[v].fiq, VECS[v].irq, VECS[v].idx);
        end

        // R9 / R12 / R3 / R4 selection and re-selection
        do_reset();
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        drive(32'h0000_0080, '0, '0, '0);
        out_check("R9 first", 1'b0, 1'b1, 5'd7);
        drive(32'h0000_0088, '0, '0, '0);
        out_check("R9 lower replaces", 1'b0, 1'b1, 5'd3);
        rd_check("R9 insvc", 3'd4, 32'h8);
        drive(32'h0010_0088, '0, '0, '0);
        out_check("R9 higher waits", 1'b0, 1'b1, 5'd3);
        wr(3'd3, 32'hFFFF_FFFF);
        out_check("R12 prio inert", 1'b0, 1'b1, 5'd3);
        wr(3'd0, 32'h8);
        rd_check("R3 R4 srcpnd", 3'd0, 32'h0010_0080);
        wr(3'd4, 32'h8);
        rd_check("R3 insvc reload", 3'd4, 32'h80);
        out_check("R9 reselect", 1'b0, 1'b1, 5'd7);
        wr(3'd0, 32'h80);
        wr(3'd4, 32'h80);
        out_check("R9 next", 1'b0, 1'b1, 5'd20);
        wr(3'd0, 32'h0010_0000);
        wr(3'd4, 32'h0010_0000);
        out_check("R10 idle", 1'b0, 1'b0, 5'd0);
        rd_check("R10 insvc", 3'd4, 32'h0);

        // R5 / R6 level and falling inputs
        do_reset();
        wr(3'd2, 32'h0);
        drive('0, 32'h400, '0, '0);
        out_check("R5 level", 1'b0, 1'b1, 5'd10);
        wr(3'd0, 32'h400);
        rd_check("R5 repend", 3'd0, 32'h400);
        drive('0, '0, '0, '0);
        rd_check("R6 level fall", 3'd0, 32'h0);
        rd_check("R10 insvc held", 3'd4, 32'h400);
        out_check("R10 held", 1'b0, 1'b1, 5'd10);
        wr(3'd4, 32'h400);
        out_check("R10 cleared", 1'b0, 1'b0, 5'd0);
        drive(32'h4, '0, '0, '0);
        rd_check("R4 edge set", 3'd0, 32'h4);
        drive('0, '0, '0, '0);
        rd_check("R6 edge fall", 3'd0, 32'h0);

        // R7 sub-source funnel
        do_reset();
        wr(3'd7, 32'h001);
        drive('0, '0, 11'h010, '0);
        rd_check("R7 sub pend", 3'd6, 32'h010);
        rd_check("R7 group1", 3'd0, 32'h0080_0000);
        drive('0, '0, 11'h210, '0);
        rd_check("R7 ungrouped", 3'd0, 32'h0080_0000);
        drive('0, '0, 11'h211, '0);
        rd_check("R7 masked sub", 3'd0, 32'h0080_0000);
        rd_check("R7 masked pend", 3'd6, 32'h211);
        drive('0, '0, 11'h211, 11'h080);
        rd_check("R7 group2", 3'd0, 32'h0080_8000);
        wr(3'd6, 32'h080);
        rd_check("R5 sub repend", 3'd6, 32'h291);
        wr(3'd7, 32'h000);
        rd_check("R7 group0", 3'd0, 32'h1080_8000);

        // R8 / R11 fast pre-emption and same-edge update
        do_reset();
        wr(3'd2, 32'h0);
        wr(3'd1, 32'h10);
        @(negedge clk);
        main_edge_req = 32'h50;
        @(posedge clk); #1;
        check("R11 fiq same edge", 32'(fiq_o), 32'h1);
        @(negedge clk);
        out_check("R8 fast", 1'b1, 1'b0, 5'd0);
        wr(3'd1, 32'h0);
        out_check("R8 normal", 1'b0, 1'b1, 5'd4);
        wr(3'd1, 32'h40);
        out_check("R8 fast keeps insvc", 1'b1, 1'b1, 5'd4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule